// File: doc/BRIEF.md
# Parallel ADC Readout Controller

This block is the host-side sequencer for a six-input converter that returns 16-bit result words over a shared parallel bus. It drives the converter's chip select, read strobe and three address lines, and it meets the converter's setup, strobe-low and strobe-high minimums by counting system clock cycles. Each minimum is a parameter in nanoseconds and is rounded up to whole cycles. With the default 5 ns clock the counts are a setup of 2 cycles, a strobe low time of 6 cycles, a long strobe low time of 10 cycles and a recovery time of 6 cycles.

A request carries a 3-bit code. Codes 0 to 5 read one input once. Code 7 drains the converter's result queue, one word after another, until a word arrives whose valid flag is clear. Code 6 is refused. A per-request byte option reads each word as two strobes on the low eight data lines. Every word is split into a valid flag, a channel tag and a 12-bit sample, and is offered on a valid/ready output.

Top module: `adc_rd_ctrl`

## Requirements
- R1: For codes 0 to 5, exactly one word is read with `adc_addr_o` equal to the requested code. The result carries chan = word[14:12], sample = word[11:0] and eof = NOT word[15].
- R2: `adc_addr_o` holds its value for at least 2 cycles before `adc_rd_no` falls, and does not change while `adc_rd_no` is low.
- R3: While `busy_i` is high when a strobe starts, `adc_rd_no` and `adc_cs_no` stay low together for exactly 6 cycles, and the data bus is sampled in the last of those cycles.
- R4: While `busy_i` is low when a strobe starts, the strobe is stretched to exactly 10 low cycles.
- R5: Between two strobes of one request, `adc_rd_no` stays high for at least 6 cycles.
- R6: With `req_byte_i` set, each word takes two strobes. The first strobe returns word[7:0] and the second returns word[15:8], both on `adc_data_i[7:0]`. `adc_data_i[15:8]` is ignored during both strobes.
- R7: Code 7 (0b111) reads words repeatedly until it gets one with bit 15 equal to 0. Every word is delivered, and only the last one has eof = 1.
- R8: Code 6 (0b110) raises `err_o` for exactly one cycle, starts no strobe and leaves `req_ready_o` high.
- R9: `req_ready_o` is low for the whole time a request is in progress. Requests presented during that time have no effect.
- R10: While `res_valid_o` is high and `res_ready_i` is low, the result stays valid and does not change.
- R11: During reset, `adc_cs_no` and `adc_rd_no` are high, `res_valid_o` and `err_o` are low, and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken while req_ready_o is high |
| req_addr_i | input | 3 | 0-5 single input, 6 refused, 7 queue drain |
| req_byte_i | input | 1 | Read each word as two byte strobes |
| busy_i | input | 1 | Converter conversion-in-progress flag (low = converting) |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| err_o | output | 1 | One-cycle pulse when a request with code 6 is refused |
| adc_cs_no | output | 1 | Converter chip select, active low |
| adc_rd_no | output | 1 | Converter read strobe, active low |
| adc_addr_o | output | 3 | Converter address lines |
| adc_data_i | input | 16 | Converter data bus |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Result consumed |
| res_chan_o | output | 3 | Channel tag of the result |
| res_sample_o | output | 12 | 12-bit sample |
| res_eof_o | output | 1 | Word's valid flag was clear (end of queue) |

## Verification
The timing assertions assume that `busy_i` does not change in the last cycle before a strobe starts, and that the converter holds `adc_data_i` steady for the whole time the strobe is low. The bench meets both conditions. It keeps `busy_i` constant for the length of each request, and its bus model drives the queued word throughout every low phase while driving a distinct junk pattern at all other times. Requests arrive only at idle, except for deliberate intrusions during a read sequence. Those intrusions are dropped well before the sequence ends, so they never fall into an idle cycle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int WORD_W   = 16;
  localparam int SAMPLE_W = 12;
  localparam int TAG_W    = 3;

  localparam logic [TAG_W-1:0] CODE_RSVD  = 3'b110;
  localparam logic [TAG_W-1:0] CODE_DRAIN = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_OUT
  } rd_state_e;

  typedef struct packed {
    logic                eof;
    logic [TAG_W-1:0]    chan;
    logic [SAMPLE_W-1:0] sample;
  } rd_result_t;

  // ceil(ns / period), never below one cycle
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/adc_rd_word.sv
module adc_rd_word
  import adc_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              byte_mode_i,
  input  logic              hi_phase_i,
  input  logic [WORD_W-1:0] bus_i,
  output logic              word_valid_o,
  output rd_result_t        result_o
);

  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] word_q;

  // each half is written from the full bus or from the low lane in byte mode
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[h*HALF_W +: HALF_W] <= '0;
      end else if (cap_i) begin
        if (!byte_mode_i)
          word_q[h*HALF_W +: HALF_W] <= bus_i[h*HALF_W +: HALF_W];
        else if (hi_phase_i == logic'(h))
          word_q[h*HALF_W +: HALF_W] <= bus_i[HALF_W-1:0];
      end
    end
  end

  assign word_valid_o    = word_q[WORD_W-1];
  assign result_o.eof    = ~word_q[WORD_W-1];
  assign result_o.chan   = word_q[SAMPLE_W +: TAG_W];
  assign result_o.sample = word_q[SAMPLE_W-1:0];

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int LOW_CYC   = 6,
  parameter int LATCH_CYC = 10,
  parameter int HIGH_CYC  = 6,
  parameter int CW        = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [TAG_W-1:0] req_addr_i,
  input  logic             req_byte_i,
  input  logic             busy_i,
  output logic             req_ready_o,
  output logic             err_o,
  output logic             cs_no,
  output logic             rd_no,
  output logic [TAG_W-1:0] addr_o,
  output logic             cap_o,
  output logic             byte_o,
  output logic             hi_phase_o,
  input  logic             word_valid_i,
  output logic             res_valid_o,
  input  logic             res_ready_i
);

  rd_state_e        state_q, state_d;
  logic [TAG_W-1:0] addr_q, addr_d;
  logic             drain_q, drain_d;
  logic             byte_q, byte_d;
  logic             phase_q, phase_d;
  logic             err_d;
  logic             t_load, t_done;
  logic [CW-1:0]    t_val;
  logic [CW-1:0]    low_len;

  // converting (busy low) may overlap the output latch: use the long strobe
  assign low_len = busy_i ? CW'(LOW_CYC - 1) : CW'(LATCH_CYC - 1);

  adc_rd_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (t_val),
    .done_o (t_done)
  );

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    drain_d = drain_q;
    byte_d  = byte_q;
    phase_d = phase_q;
    err_d   = 1'b0;
    t_load  = 1'b0;
    t_val   = '0;
    cap_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (req_addr_i == CODE_RSVD) begin
            err_d = 1'b1;
          end else begin
            addr_d  = req_addr_i;
            drain_d = (req_addr_i == CODE_DRAIN);
            byte_d  = req_byte_i;
            phase_d = 1'b0;
            t_load  = 1'b1;
            t_val   = CW'(SETUP_CYC - 1);
            state_d = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        if (t_done) begin
          t_load  = 1'b1;
          t_val   = low_len;
          state_d = ST_LOW;
        end
      end
      ST_LOW: begin
        if (t_done) begin
          cap_o   = 1'b1;
          t_load  = 1'b1;
          t_val   = CW'(HIGH_CYC - 1);
          state_d = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (t_done) begin
          if (byte_q && !phase_q) begin
            phase_d = 1'b1;
            t_load  = 1'b1;
            t_val   = low_len;
            state_d = ST_LOW;
          end else begin
            state_d = ST_OUT;
          end
        end
      end
      ST_OUT: begin
        if (res_ready_i) begin
          if (drain_q && word_valid_i) begin
            // recovery already spent in ST_HIGH
            phase_d = 1'b0;
            t_load  = 1'b1;
            t_val   = low_len;
            state_d = ST_LOW;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      drain_q <= 1'b0;
      byte_q  <= 1'b0;
      phase_q <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      drain_q <= drain_d;
      byte_q  <= byte_d;
      phase_q <= phase_d;
      err_o   <= err_d;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign cs_no       = (state_q == ST_IDLE);
  assign rd_no       = (state_q != ST_LOW);
  assign res_valid_o = (state_q == ST_OUT);
  assign addr_o      = addr_q;
  assign byte_o      = byte_q;
  assign hi_phase_o  = phase_q;

  // R9
  ignore_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (addr_q == $past(addr_q)) || (state_q == ST_LOW && $past(state_q) == ST_OUT) || $past(state_q == ST_OUT));

  // R8
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i && req_addr_i == CODE_RSVD) && state_q == ST_IDLE);

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int CLK_PERIOD_NS  = 5,
  parameter int ADDR_SETUP_NS  = 10,
  parameter int STROBE_LOW_NS  = 30,
  parameter int LATCH_LOW_NS   = 50,
  parameter int STROBE_HIGH_NS = 30
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [TAG_W-1:0]    req_addr_i,
  input  logic                req_byte_i,
  input  logic                busy_i,
  output logic                req_ready_o,
  output logic                err_o,
  output logic                adc_cs_no,
  output logic                adc_rd_no,
  output logic [TAG_W-1:0]    adc_addr_o,
  input  logic [WORD_W-1:0]   adc_data_i,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic [TAG_W-1:0]    res_chan_o,
  output logic [SAMPLE_W-1:0] res_sample_o,
  output logic                res_eof_o
);

  localparam int SETUP_CYC = ns_to_cyc(ADDR_SETUP_NS, CLK_PERIOD_NS);
  localparam int LOW_CYC   = ns_to_cyc(STROBE_LOW_NS, CLK_PERIOD_NS);
  localparam int LATCH_CYC = (ns_to_cyc(LATCH_LOW_NS, CLK_PERIOD_NS) > LOW_CYC) ?
                              ns_to_cyc(LATCH_LOW_NS, CLK_PERIOD_NS) : LOW_CYC;
  localparam int HIGH_CYC  = ns_to_cyc(STROBE_HIGH_NS, CLK_PERIOD_NS);
  localparam int MAX_A     = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int MAX_CYC   = (MAX_A > LATCH_CYC) ? MAX_A : LATCH_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1) + 1;

  logic       cap, byte_mode, hi_phase, word_valid;
  rd_result_t result;

  adc_rd_seq #(
    .SETUP_CYC (SETUP_CYC),
    .LOW_CYC   (LOW_CYC),
    .LATCH_CYC (LATCH_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .CW        (CW)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_addr_i   (req_addr_i),
    .req_byte_i   (req_byte_i),
    .busy_i       (busy_i),
    .req_ready_o  (req_ready_o),
    .err_o        (err_o),
    .cs_no        (adc_cs_no),
    .rd_no        (adc_rd_no),
    .addr_o       (adc_addr_o),
    .cap_o        (cap),
    .byte_o       (byte_mode),
    .hi_phase_o   (hi_phase),
    .word_valid_i (word_valid),
    .res_valid_o  (res_valid_o),
    .res_ready_i  (res_ready_i)
  );

  adc_rd_word u_word (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_i        (cap),
    .byte_mode_i  (byte_mode),
    .hi_phase_i   (hi_phase),
    .bus_i        (adc_data_i),
    .word_valid_o (word_valid),
    .result_o     (result)
  );

  assign res_chan_o   = result.chan;
  assign res_sample_o = result.sample;
  assign res_eof_o    = result.eof;

  // pin-level timing observers for the assertions below
  localparam logic [CW-1:0] SAT = '1;
  logic [CW-1:0]    lo_cnt_q, hi_cnt_q, addr_cnt_q, addr_age;
  logic [TAG_W-1:0] addr_prev_q;

  assign addr_age = (adc_addr_o != addr_prev_q) ? '0 : addr_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt_q    <= '0;
      hi_cnt_q    <= SAT;
      addr_cnt_q  <= SAT;
      addr_prev_q <= '0;
    end else begin
      lo_cnt_q    <= adc_rd_no ? '0 : ((lo_cnt_q == SAT) ? SAT : lo_cnt_q + 1'b1);
      hi_cnt_q    <= !adc_rd_no ? '0 : ((hi_cnt_q == SAT) ? SAT : hi_cnt_q + 1'b1);
      addr_cnt_q  <= (addr_age == SAT) ? SAT : addr_age + 1'b1;
      addr_prev_q <= adc_addr_o;
    end
  end

  // R2
  addr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_rd_no) |-> addr_age >= CW'(SETUP_CYC));

  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_rd_no |-> $stable(adc_addr_o));

  // R3
  strobe_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_rd_no) |-> lo_cnt_q >= CW'(LOW_CYC));

  // R3
  cs_with_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_rd_no |-> !adc_cs_no);

  // R5
  strobe_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_rd_no) |-> hi_cnt_q >= CW'(HIGH_CYC));

  // R1
  no_rsvd_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_rd_no |-> adc_addr_o != CODE_RSVD);

  // R9
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_cs_no |-> !req_ready_o);

  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> res_valid_o && $stable(res_chan_o)
      && $stable(res_sample_o) && $stable(res_eof_o));

endmodule

// File: tb/adc_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_rd_ctrl_tb_top;

  localparam int SETUP_C = 2;
  localparam int LOW_C   = 6;
  localparam int LATCH_C = 10;
  localparam int HIGH_C  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_addr = 3'd0;
  logic        req_byte = 1'b0;
  logic        busy = 1'b1;
  logic        req_ready, err, cs_n, rd_n;
  logic [2:0]  addr;
  logic [15:0] data;
  logic        res_valid, res_ready = 1'b0;
  logic [2:0]  res_chan;
  logic [11:0] res_sample;
  logic        res_eof;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] words [16];
  int          strobes = 0;
  logic [2:0]  exp_addr = 3'd0;
  int          exp_low = LOW_C;
  logic        cur_byte = 1'b0;

  always #2.5 clk = ~clk;

  adc_rd_ctrl dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_addr_i   (req_addr),
    .req_byte_i   (req_byte),
    .busy_i       (busy),
    .req_ready_o  (req_ready),
    .err_o        (err),
    .adc_cs_no    (cs_n),
    .adc_rd_no    (rd_n),
    .adc_addr_o   (addr),
    .adc_data_i   (data),
    .res_valid_o  (res_valid),
    .res_ready_i  (res_ready),
    .res_chan_o   (res_chan),
    .res_sample_o (res_sample),
    .res_eof_o    (res_eof)
  );

  // converter bus model: word (or byte lane) while strobed, junk otherwise
  always_comb begin
    logic [15:0] w;
    w = words[cur_byte ? ((strobes >> 1) & 15) : (strobes & 15)];
    if (!cs_n && !rd_n)
      data = cur_byte ? {8'hC3, (strobes % 2 == 1) ? w[15:8] : w[7:0]} : w;
    else
      data = 16'h5A5A;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // pin timing monitor
  logic       prev_rd = 1'b1;
  logic [2:0] prev_addr = 3'd0;
  int         addr_held = 0, low_len = 0, high_len = 100;
  bit         addr_moved = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (addr != prev_addr) addr_held = 1; else addr_held++;
      if (prev_rd && !rd_n) begin
        chk(addr == exp_addr, "R1 address at strobe", addr, exp_addr);
        chk(addr_held - 1 >= SETUP_C, "R2 address setup", addr_held - 1, SETUP_C);
        chk(!cs_n, "R3 chip select with strobe", cs_n, 0);
        if (strobes > 0) chk(high_len >= HIGH_C, "R5 recovery", high_len, HIGH_C);
        low_len = 0;
        addr_moved = 1'b0;
      end
      if (!rd_n) begin
        low_len++;
        if (!prev_rd && addr != prev_addr) addr_moved = 1'b1;
      end
      if (!prev_rd && rd_n) begin
        chk(low_len == exp_low, (exp_low == LOW_C) ? "R3 strobe width" : "R4 long strobe width",
            low_len, exp_low);
        chk(!addr_moved, "R2 address hold", addr_moved, 0);
        strobes++;
        high_len = 0;
      end
      if (rd_n) high_len++;
      prev_rd   = rd_n;
      prev_addr = addr;
    end
  end

  task automatic run_req(input logic [2:0] a, input bit bm, input bit by, input int nv,
                         input bit intrude);
    int nres, got, spur, guard;
    logic [15:0] w;
    bit held;
    logic [2:0]  h_chan;
    logic [11:0] h_sample;
    logic        h_eof;
    nres = (a == 3'b111) ? nv + 1 : 1;
    for (int i = 0; i < nres; i++) begin
      w[11:0]  = 12'($urandom);
      w[14:12] = (a == 3'b111) ? 3'($urandom % 6) : a;
      w[15]    = (a == 3'b111) ? (i < nv) : ($urandom % 4 != 0);
      words[i] = w;
    end
    while (!req_ready) @(negedge clk);
    busy = by; cur_byte = bm; exp_addr = a; exp_low = by ? LOW_C : LATCH_C;
    strobes = 0;
    req_valid = 1'b1; req_addr = a; req_byte = bm;
    @(negedge clk);
    chk(!req_ready, "R9 ready drops on accept", req_ready, 0);
    spur = intrude ? 3 : 0;
    req_valid = intrude;
    req_addr  = 3'b110;
    req_byte  = ~bm;
    got = 0; guard = 0; held = 1'b0;
    while (got < nres && guard < 5000) begin
      guard++;
      if (held) begin
        chk(res_valid && res_chan == h_chan && res_sample == h_sample && res_eof == h_eof,
            "R10 result held", {res_valid, res_chan, res_sample}, {1'b1, h_chan, h_sample});
        held = 1'b0;
      end
      if (spur > 0) begin
        chk(!req_ready && !err, "R9 intrusion ignored", {req_ready, err}, 0);
        spur--;
        if (spur == 0) req_valid = 1'b0;
      end
      res_ready = ($urandom % 3 != 0);
      if (res_valid) begin
        if (res_ready) begin
          w = words[got];
          chk(res_chan == w[14:12], (a == 3'b111) ? "R7 tag" : "R1 tag", res_chan, w[14:12]);
          chk(res_sample == w[11:0], bm ? "R6 sample" : "R1 sample", res_sample, w[11:0]);
          chk(res_eof == ~w[15], (a == 3'b111) ? "R7 eof" : "R1 eof", res_eof, ~w[15]);
          got++;
        end else begin
          held = 1'b1; h_chan = res_chan; h_sample = res_sample; h_eof = res_eof;
        end
      end
      @(negedge clk);
    end
    res_ready = 1'b0;
    req_valid = 1'b0;
    chk(got == nres, "R7 result count", got, nres);
    chk(strobes == nres * (bm ? 2 : 1), bm ? "R6 strobe count" : "R9 strobe count",
        strobes, nres * (bm ? 2 : 1));
    chk(req_ready && cs_n, "R9 idle after request", {req_ready, cs_n}, 2'b11);
    busy = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) words[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk(cs_n && rd_n && !res_valid && !err && req_ready, "R11 reset state",
        {cs_n, rd_n, res_valid, err, req_ready}, 5'b11001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && rd_n && !res_valid && req_ready, "R11 after release",
        {cs_n, rd_n, res_valid, req_ready}, 4'b1101);

    // R8 refused code
    req_valid = 1'b1; req_addr = 3'b110;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err && cs_n && req_ready, "R8 error pulse", {err, cs_n, req_ready}, 3'b111);
    @(negedge clk);
    chk(!err && cs_n && rd_n && strobes == 0, "R8 single cycle, no strobe",
        {err, cs_n, rd_n}, 3'b011);

    for (int a = 0; a < 6; a++) run_req(3'(a), 1'b0, 1'b1, 0, 1'b0);   // R1 R3
    run_req(3'd2, 1'b0, 1'b0, 0, 1'b0);                                // R4
    run_req(3'd5, 1'b1, 1'b1, 0, 1'b0);                                // R6
    run_req(3'd0, 1'b1, 1'b0, 0, 1'b1);                                // R6 R4 R9
    run_req(3'b111, 1'b0, 1'b1, 0, 1'b0);                              // R7 empty queue
    run_req(3'b111, 1'b0, 1'b1, 5, 1'b1);                              // R7 R5
    run_req(3'b111, 1'b1, 1'b0, 3, 1'b0);                              // R7 R6
    for (int k = 0; k < 40; k++) begin
      logic [2:0] ra;
      ra = ($urandom % 4 == 0) ? 3'b111 : 3'($urandom % 6);
      run_req(ra, 1'($urandom), 1'($urandom), int'($urandom % 6), 1'($urandom));
    end
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    report();
    $finish;
  end

endmodule